// File: doc/BRIEF.md
# Thread-Block Work Distributor

This block hands out the thread blocks of queued kernel launches to a row of compute units. A launch carries three numbers: how many blocks the kernel has, how much shared memory each block needs and how many registers each block needs. The distributor keeps a table of kernels in flight and gives each launch a kernel ID. It walks through the blocks of the oldest kernel that still has blocks waiting. A block goes to a unit only if the unit has a free resident-block slot and enough spare shared memory and enough spare registers for it. Among the units that can take the block, the one with the lowest number wins.

Kernels are served strictly in launch order. A large kernel can fill every unit, and then the next kernel waits. Its blocks start only as completion pulses from the units give back capacity, so two neighbouring kernels overlap only partly. Each unit reports a finished block with a one-cycle pulse that carries the block's kernel ID. When every block of a kernel has finished, the distributor raises a kernel-done pulse with that ID and frees the table entry for a new launch. The blocks themselves run outside this block.

Top module: `block_distributor`

## Requirements
- R1: After reset, `dispValid` and `kernelDoneValid` are 0 and `launchReady` is 1.
- R2: Launches receive kernel IDs 0, 1, 2 … in order, wrapping modulo 2^KID_W. The first block of a launch taken at clock edge e appears on the dispatch outputs after edge e+1. Blocks of one kernel are dispatched at most one per cycle, with block indices rising from 0.
- R3: Each block goes to the lowest-numbered unit that meets all three limits at that moment.
- R4: A unit never holds more than SLOTS resident blocks (default 16).
- R5: The shared memory of the resident blocks on a unit never adds up to more than SMEM_BUDGET (default 48, in KB). For example, blocks of 10 KB fill a unit at 4.
- R6: The registers of the resident blocks on a unit never add up to more than REG_BUDGET (default 65536).
- R7: No block of a later kernel is dispatched while an earlier kernel still has undispatched blocks, even if the later block would fit. After the last block of a kernel is dispatched, one idle cycle passes before the next kernel's first block is dispatched.
- R8: A completion pulse captured at edge c returns the slot, shared memory and registers of that block to its unit. A waiting block can then be dispatched at edge c+1.
- R9: When the final completion of a kernel is captured at edge c, `kernelDoneValid` is 1 for one cycle after edge c+1, and `kernelDoneId` carries the kernel ID.
- R10: While 2^KID_W kernels are in flight, `launchReady` is 0. It rises in the cycle that an in-flight kernel's done pulse is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| launchValid | input | 1 | A kernel launch is offered |
| launchReady | output | 1 | A free kernel table entry exists |
| launchBlocks | input | BLK_W | Number of blocks in the launched kernel |
| launchSmem | input | SMEM_W | Shared memory per block, in KB |
| launchRegs | input | REG_W | Registers per block |
| doneValid | input | UNITS | Per-unit block completion pulse |
| doneKernel | input | UNITS*KID_W | Kernel ID of the completing block, one field per unit (unit u at bits u*KID_W upward) |
| dispValid | output | 1 | A block is dispatched this cycle |
| dispUnit | output | UW | Target unit of the dispatched block |
| dispKernel | output | KID_W | Kernel ID of the dispatched block |
| dispBlock | output | BLK_W | Block index within its kernel |
| kernelDoneValid | output | 1 | A kernel has completed all its blocks |
| kernelDoneId | output | KID_W | ID of the completed kernel |

## Verification
Every result comes out of a register, so each one is due at a fixed number of edges after its stimulus. The first block of a launch appears two edges after the launch is offered. A block freed by a completion pulse appears two edges after the pulse. A kernel-done pulse appears two edges after the final completion is offered. The bench drives inputs and samples outputs on falling edges. It checks the dispatch outputs at every falling edge while blocks are expected, so a block that comes a cycle early, comes a cycle late or goes to the wrong unit is reported. Idle cycles are checked to be quiet in the stall windows of R7 and R8.

// File: rtl/wd_pkg.sv
package wd_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic takeLaunch;    // write launch into table at tail
    logic issueBlock;    // charge one block of head kernel to issueUnit
    logic retireKernel;  // release table entry retireKid
  } wdStrobe_t;
endpackage

// File: rtl/wd_datapath.sv
module wd_datapath
  import wd_pkg::*;
#(
  parameter int UNITS       = 4,
  parameter int SLOTS       = 16,
  parameter int SMEM_BUDGET = 48,
  parameter int REG_BUDGET  = 65536,
  parameter int KID_W       = 3,
  parameter int BLK_W       = 10,
  parameter int UW          = 2,
  parameter int SMEM_W      = 6,
  parameter int REG_W       = 17,
  parameter int KERNELS     = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  wdStrobe_t              strobe,
  input  logic [UW-1:0]          issueUnit,
  input  logic [KID_W-1:0]       headKid,
  input  logic [KID_W-1:0]       tailKid,
  input  logic [KID_W-1:0]       retireKid,
  input  logic [BLK_W-1:0]       launchBlocks,
  input  logic [SMEM_W-1:0]      launchSmem,
  input  logic [REG_W-1:0]       launchRegs,
  input  logic [UNITS-1:0]       doneValid,
  input  logic [UNITS*KID_W-1:0] doneKid,
  output logic [UNITS-1:0]       unitFits,
  output logic                   headPending,
  output logic [BLK_W-1:0]       headNextBlk,
  output logic [KERNELS-1:0]     kernelActive,
  output logic [KERNELS-1:0]     kernelComplete
);
  localparam int SLOT_W = $clog2(SLOTS + 1);
  localparam int CNT_W  = $clog2(UNITS + 1);
  localparam logic [SLOT_W-1:0] SLOT_LIM = SLOT_W'(SLOTS);
  localparam logic [SMEM_W:0]   SMEM_LIM = (SMEM_W+1)'(SMEM_BUDGET);
  localparam logic [REG_W:0]    REG_LIM  = (REG_W+1)'(REG_BUDGET);

  // kernel table
  logic [KERNELS-1:0] kActive;
  logic [BLK_W-1:0]   kTotal    [KERNELS];
  logic [BLK_W-1:0]   kIssued   [KERNELS];
  logic [BLK_W-1:0]   kFinished [KERNELS];
  logic [SMEM_W-1:0]  kSmem     [KERNELS];
  logic [REG_W-1:0]   kRegs     [KERNELS];

  // per-unit occupancy
  logic [SLOT_W-1:0]  slotsUsed [UNITS];
  logic [SMEM_W-1:0]  smemUsed  [UNITS];
  logic [REG_W-1:0]   regsUsed  [UNITS];

  logic [CNT_W-1:0]   finCount  [KERNELS];
  logic [SMEM_W-1:0]  addSmem   [UNITS];
  logic [REG_W-1:0]   addRegs   [UNITS];
  logic [SMEM_W-1:0]  retSmem   [UNITS];
  logic [REG_W-1:0]   retRegs   [UNITS];
  logic [UNITS-1:0]   addSlot;

  // completions landing on each kernel this cycle
  always_comb begin
    for (int k = 0; k < KERNELS; k++) begin
      finCount[k] = '0;
      for (int u = 0; u < UNITS; u++)
        if (doneValid[u] && doneKid[u*KID_W +: KID_W] == KID_W'(k))
          finCount[k] = finCount[k] + 1'b1;
    end
  end

  // charges and refunds per unit
  always_comb begin
    for (int u = 0; u < UNITS; u++) begin
      addSlot[u] = strobe.issueBlock && (issueUnit == UW'(u));
      addSmem[u] = addSlot[u] ? kSmem[headKid] : '0;
      addRegs[u] = addSlot[u] ? kRegs[headKid] : '0;
      retSmem[u] = doneValid[u] ? kSmem[doneKid[u*KID_W +: KID_W]] : '0;
      retRegs[u] = doneValid[u] ? kRegs[doneKid[u*KID_W +: KID_W]] : '0;
    end
  end

  // room check against the head kernel's per-block demand
  always_comb begin
    for (int u = 0; u < UNITS; u++) begin
      unitFits[u] = (slotsUsed[u] < SLOT_LIM)
                 && (({1'b0, smemUsed[u]} + {1'b0, kSmem[headKid]}) <= SMEM_LIM)
                 && (({1'b0, regsUsed[u]} + {1'b0, kRegs[headKid]}) <= REG_LIM);
    end
  end

  assign headPending = kActive[headKid] && (kIssued[headKid] != kTotal[headKid]);
  assign headNextBlk = kIssued[headKid];
  assign kernelActive = kActive;

  always_comb begin
    for (int k = 0; k < KERNELS; k++)
      kernelComplete[k] = kActive[k] && (kIssued[k] == kTotal[k])
                          && (kFinished[k] == kTotal[k]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kActive <= '0;
      for (int k = 0; k < KERNELS; k++) begin
        kTotal[k]    <= '0;
        kIssued[k]   <= '0;
        kFinished[k] <= '0;
        kSmem[k]     <= '0;
        kRegs[k]     <= '0;
      end
    end else begin
      for (int k = 0; k < KERNELS; k++) begin
        if (strobe.takeLaunch && tailKid == KID_W'(k)) begin
          kActive[k]   <= 1'b1;
          kTotal[k]    <= launchBlocks;
          kIssued[k]   <= '0;
          kFinished[k] <= '0;
          kSmem[k]     <= launchSmem;
          kRegs[k]     <= launchRegs;
        end else begin
          if (strobe.retireKernel && retireKid == KID_W'(k)) kActive[k] <= 1'b0;
          if (strobe.issueBlock && headKid == KID_W'(k)) kIssued[k] <= kIssued[k] + 1'b1;
          kFinished[k] <= kFinished[k] + BLK_W'(finCount[k]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int u = 0; u < UNITS; u++) begin
        slotsUsed[u] <= '0;
        smemUsed[u]  <= '0;
        regsUsed[u]  <= '0;
      end
    end else begin
      for (int u = 0; u < UNITS; u++) begin
        slotsUsed[u] <= slotsUsed[u] + SLOT_W'(addSlot[u]) - SLOT_W'(doneValid[u]);
        smemUsed[u]  <= smemUsed[u] + addSmem[u] - retSmem[u];
        regsUsed[u]  <= regsUsed[u] + addRegs[u] - retRegs[u];
      end
    end
  end

  for (genvar gu = 0; gu < UNITS; gu++) begin : g_unitChecks
    assert_slot_cap_R4: assert property (@(posedge clk) disable iff (!rstN)
      slotsUsed[gu] <= SLOT_LIM);
    assert_smem_cap_R5: assert property (@(posedge clk) disable iff (!rstN)
      {1'b0, smemUsed[gu]} <= SMEM_LIM);
    assert_regs_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
      {1'b0, regsUsed[gu]} <= REG_LIM);
  end

  for (genvar gk = 0; gk < KERNELS; gk++) begin : g_kernelChecks
    assert_finish_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
      kActive[gk] |-> (kFinished[gk] <= kIssued[gk]));
  end
endmodule

// File: rtl/wd_control.sv
module wd_control
  import wd_pkg::*;
#(
  parameter int UNITS   = 4,
  parameter int KID_W   = 3,
  parameter int BLK_W   = 10,
  parameter int UW      = 2,
  parameter int KERNELS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               launchValid,
  output logic               launchReady,
  input  logic [UNITS-1:0]   unitFits,
  input  logic               headPending,
  input  logic [BLK_W-1:0]   headNextBlk,
  input  logic [KERNELS-1:0] kernelActive,
  input  logic [KERNELS-1:0] kernelComplete,
  output wdStrobe_t          strobe,
  output logic [UW-1:0]      issueUnit,
  output logic [KID_W-1:0]   headKid,
  output logic [KID_W-1:0]   tailKid,
  output logic [KID_W-1:0]   retireKid,
  output logic               dispValid,
  output logic [UW-1:0]      dispUnit,
  output logic [KID_W-1:0]   dispKernel,
  output logic [BLK_W-1:0]   dispBlock,
  output logic               kernelDoneValid,
  output logic [KID_W-1:0]   kernelDoneId
);
  logic [KID_W-1:0] headPtr, tailPtr;
  logic             retireAny, headAdvance;

  assign headKid = headPtr;
  assign tailKid = tailPtr;
  assign launchReady = !kernelActive[tailPtr];
  assign headAdvance = kernelActive[headPtr] && !headPending;

  // lowest unit with room
  always_comb begin
    issueUnit = '0;
    for (int u = UNITS - 1; u >= 0; u--)
      if (unitFits[u]) issueUnit = UW'(u);
  end

  // lowest finished kernel
  always_comb begin
    retireKid = '0;
    retireAny = 1'b0;
    for (int k = KERNELS - 1; k >= 0; k--)
      if (kernelComplete[k]) begin
        retireKid = KID_W'(k);
        retireAny = 1'b1;
      end
  end

  always_comb begin
    strobe.takeLaunch   = launchValid && launchReady;
    strobe.issueBlock   = headPending && (|unitFits);
    strobe.retireKernel = retireAny;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr         <= '0;
      tailPtr         <= '0;
      dispValid       <= 1'b0;
      dispUnit        <= '0;
      dispKernel      <= '0;
      dispBlock       <= '0;
      kernelDoneValid <= 1'b0;
      kernelDoneId    <= '0;
    end else begin
      if (strobe.takeLaunch) tailPtr <= tailPtr + 1'b1;
      if (headAdvance)       headPtr <= headPtr + 1'b1;
      dispValid       <= strobe.issueBlock;
      dispUnit        <= issueUnit;
      dispKernel      <= headPtr;
      dispBlock       <= headNextBlk;
      kernelDoneValid <= retireAny;
      kernelDoneId    <= retireKid;
    end
  end

  assert_ready_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    (launchValid && !launchReady) |=> $stable(tailPtr));

  assert_block_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && $past(dispValid) && dispKernel == $past(dispKernel))
      |-> (dispBlock == $past(dispBlock) + 1'b1));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    kernelDoneValid |=> !(kernelDoneValid && kernelDoneId == $past(kernelDoneId)));
endmodule

// File: rtl/block_distributor.sv
module block_distributor
  import wd_pkg::*;
#(
  parameter int UNITS       = 4,
  parameter int SLOTS       = 16,
  parameter int SMEM_BUDGET = 48,
  parameter int REG_BUDGET  = 65536,
  parameter int KID_W       = 3,
  parameter int BLK_W       = 10,
  parameter int UW          = (UNITS > 1) ? $clog2(UNITS) : 1,
  parameter int SMEM_W      = $clog2(SMEM_BUDGET + 1),
  parameter int REG_W       = $clog2(REG_BUDGET + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   launchValid,
  output logic                   launchReady,
  input  logic [BLK_W-1:0]       launchBlocks,
  input  logic [SMEM_W-1:0]      launchSmem,
  input  logic [REG_W-1:0]       launchRegs,
  input  logic [UNITS-1:0]       doneValid,
  input  logic [UNITS*KID_W-1:0] doneKernel,
  output logic                   dispValid,
  output logic [UW-1:0]          dispUnit,
  output logic [KID_W-1:0]       dispKernel,
  output logic [BLK_W-1:0]       dispBlock,
  output logic                   kernelDoneValid,
  output logic [KID_W-1:0]       kernelDoneId
);
  localparam int KERNELS = 1 << KID_W;

  wdStrobe_t          strobe;
  logic [UW-1:0]      issueUnit;
  logic [KID_W-1:0]   headKid, tailKid, retireKid;
  logic [UNITS-1:0]   unitFits;
  logic               headPending;
  logic [BLK_W-1:0]   headNextBlk;
  logic [KERNELS-1:0] kernelActive, kernelComplete;

  wd_control #(
    .UNITS(UNITS), .KID_W(KID_W), .BLK_W(BLK_W), .UW(UW), .KERNELS(KERNELS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .launchValid(launchValid), .launchReady(launchReady),
    .unitFits(unitFits), .headPending(headPending), .headNextBlk(headNextBlk),
    .kernelActive(kernelActive), .kernelComplete(kernelComplete),
    .strobe(strobe), .issueUnit(issueUnit),
    .headKid(headKid), .tailKid(tailKid), .retireKid(retireKid),
    .dispValid(dispValid), .dispUnit(dispUnit), .dispKernel(dispKernel),
    .dispBlock(dispBlock),
    .kernelDoneValid(kernelDoneValid), .kernelDoneId(kernelDoneId)
  );

  wd_datapath #(
    .UNITS(UNITS), .SLOTS(SLOTS), .SMEM_BUDGET(SMEM_BUDGET), .REG_BUDGET(REG_BUDGET),
    .KID_W(KID_W), .BLK_W(BLK_W), .UW(UW), .SMEM_W(SMEM_W), .REG_W(REG_W),
    .KERNELS(KERNELS)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .issueUnit(issueUnit),
    .headKid(headKid), .tailKid(tailKid), .retireKid(retireKid),
    .launchBlocks(launchBlocks), .launchSmem(launchSmem), .launchRegs(launchRegs),
    .doneValid(doneValid), .doneKid(doneKernel),
    .unitFits(unitFits), .headPending(headPending), .headNextBlk(headNextBlk),
    .kernelActive(kernelActive), .kernelComplete(kernelComplete)
  );
endmodule

// File: tb/block_distributor_test.sv
`timescale 1ns/1ps
module block_distributor_test;
  localparam int UNITS = 4;
  localparam int KID_W = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        launchValid = 1'b0;
  logic        launchReady;
  logic [9:0]  launchBlocks = '0;
  logic [5:0]  launchSmem = '0;
  logic [16:0] launchRegs = '0;
  logic [3:0]  doneValid = '0;
  logic [11:0] doneKernel = '0;
  logic        dispValid;
  logic [1:0]  dispUnit;
  logic [2:0]  dispKernel;
  logic [9:0]  dispBlock;
  logic        kernelDoneValid;
  logic [2:0]  kernelDoneId;

  int nChecks = 0;
  int nFails  = 0;
  int nextKid = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  block_distributor uut (
    .clk(clk), .rstN(rstN),
    .launchValid(launchValid), .launchReady(launchReady),
    .launchBlocks(launchBlocks), .launchSmem(launchSmem), .launchRegs(launchRegs),
    .doneValid(doneValid), .doneKernel(doneKernel),
    .dispValid(dispValid), .dispUnit(dispUnit), .dispKernel(dispKernel),
    .dispBlock(dispBlock),
    .kernelDoneValid(kernelDoneValid), .kernelDoneId(kernelDoneId)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expDisp(input string req, input int unit, input int kid, input int blk);
    @(negedge clk);
    chk({req, " valid"}, int'(dispValid), 1);
    chk({req, " unit"},  int'(dispUnit), unit);
    chk({req, " kernel"}, int'(dispKernel), kid);
    chk({req, " block"}, int'(dispBlock), blk);
  endtask

  task automatic expQuiet(input string req);
    @(negedge clk);
    chk({req, " idle"}, int'(dispValid), 0);
  endtask

  task automatic expDone(input string req, input int kid);
    @(negedge clk);
    chk({req, " done"}, int'(kernelDoneValid), 1);
    chk({req, " doneId"}, int'(kernelDoneId), kid);
  endtask

  task automatic doLaunch(input int blocks, input int smem, input int regs, output int kid);
    launchValid  = 1'b1;
    launchBlocks = 10'(blocks);
    launchSmem   = 6'(smem);
    launchRegs   = 17'(regs);
    kid = nextKid;
    nextKid = (nextKid + 1) % 8;
    @(negedge clk);
    launchValid = 1'b0;
  endtask

  task automatic doDone(input logic [3:0] mask, input int kid);
    doneValid  = mask;
    doneKernel = {UNITS{3'(kid)}};
    @(negedge clk);
    doneValid = '0;
  endtask

  task automatic testReset();
    chk("R1 dispValid", int'(dispValid), 0);
    chk("R1 kernelDoneValid", int'(kernelDoneValid), 0);
    chk("R1 launchReady", int'(launchReady), 1);
  endtask

  task automatic testSingle();
    int k;
    doLaunch(6, 4, 1000, k);
    for (int b = 0; b < 6; b++) expDisp("R2 sequence", 0, k, b);
    expQuiet("R2 end");
    for (int i = 0; i < 6; i++) doDone(4'b0001, k);
    expDone("R9 single", k);
  endtask

  task automatic testSlots();
    int k;
    doLaunch(20, 0, 0, k);
    for (int b = 0; b < 20; b++) expDisp("R4 slot cap", (b < 16) ? 0 : 1, k, b);
    for (int i = 0; i < 4; i++)  doDone(4'b0011, k);
    for (int i = 0; i < 12; i++) doDone(4'b0001, k);
    expDone("R9 slots", k);
  endtask

  task automatic testSmem();
    int k;
    doLaunch(10, 10, 0, k);
    for (int b = 0; b < 10; b++) expDisp("R5 smem cap", b / 4, k, b);
    for (int i = 0; i < 2; i++) doDone(4'b0111, k);
    for (int i = 0; i < 2; i++) doDone(4'b0011, k);
    expDone("R9 smem", k);
  endtask

  task automatic testRegs();
    int k;
    doLaunch(9, 0, 20000, k);
    for (int b = 0; b < 9; b++) expDisp("R6 reg cap", b / 3, k, b);
    for (int i = 0; i < 3; i++) doDone(4'b0111, k);
    expDone("R9 regs", k);
  endtask

  task automatic testDrain();
    int ka, kb;
    doLaunch(16, 10, 0, ka);
    for (int b = 0; b < 16; b++) expDisp("R3 fill", b / 4, ka, b);
    doLaunch(1, 10, 0, kb);
    for (int i = 0; i < 3; i++) expQuiet("R8 full wait");
    doDone(4'b0100, ka);
    chk("R8 not early", int'(dispValid), 0);
    expDisp("R8 freed unit", 2, kb, 0);
    for (int i = 0; i < 3; i++) doDone(4'b1111, ka);
    doDone(4'b1011, ka);
    expDone("R9 drain first", ka);
    doDone(4'b0100, kb);
    expDone("R9 drain second", kb);
  endtask

  task automatic testOrder();
    int ka, kb;
    doLaunch(8, 48, 0, ka);
    for (int b = 0; b < 4; b++) expDisp("R3 one per unit", b, ka, b);
    doLaunch(1, 0, 0, kb);
    for (int i = 0; i < 3; i++) expQuiet("R7 later waits");
    doDone(4'b0010, ka); expDisp("R7 refill", 1, ka, 4);
    doDone(4'b0001, ka); expDisp("R7 refill", 0, ka, 5);
    doDone(4'b1000, ka); expDisp("R7 refill", 3, ka, 6);
    doDone(4'b0100, ka); expDisp("R7 refill", 2, ka, 7);
    expQuiet("R7 gap");
    expDisp("R7 next kernel", 0, kb, 0);
    doDone(4'b1111, ka);
    expDone("R9 order first", ka);
    doDone(4'b0001, kb);
    expDone("R9 order second", kb);
  endtask

  task automatic testFull();
    int kids[8];
    for (int i = 0; i < 8; i++) doLaunch(1, 0, 0, kids[i]);
    repeat (20) @(negedge clk);
    chk("R10 full", int'(launchReady), 0);
    doDone(4'b0001, kids[0]);
    expDone("R10 retire", kids[0]);
    chk("R10 ready again", int'(launchReady), 1);
    for (int i = 1; i < 8; i++) begin
      doDone(4'b0001, kids[i]);
      expDone("R9 wrap", kids[i]);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testSlots();
    testSmem();
    testRegs();
    testDrain();
    testOrder();
    testFull();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule